// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Memory Port Guard

This block guards 32-bit words that pass through one streaming memory port. On the write side it turns a 26-bit data payload into a 32-bit codeword: five Hamming parity bits plus one bit of overall parity. On the read side it checks each stored codeword in a two-stage pipeline that takes one word per clock. A single flipped bit anywhere in the codeword is repaired. Two flipped bits are detected but cannot be repaired.

An uncorrectable word is never passed on with its corrupted payload. A substitute takes its place and the word leaves with an error flag. A mode input picks the substitute. One choice is all zeros. The other is the average of the previous and next samples of the same burst, which suits slowly varying sample streams. Two saturating counters record repaired and unrepairable words, and a sticky flag can drive an interrupt line. A single pulse input clears the counters and the flag.

Top module: `ecc_mem_port`

## Requirements
- R1: Codeword layout: bit 0 makes the XOR of all 32 bits zero. Bit 2^k (k = 0..4) is the XOR of every other bit whose index has bit k set. Payload bits d[0]..d[25] fill the remaining indices 3,5,6,7,9..15,17..31 in ascending order.
- R2: The encoder output is registered. While enc_valid is high and enc_ready is low, enc_word holds and wr_ready is low. With enc_ready high, one payload is taken per clock.
- R3: A codeword with no flipped bit comes out with its payload unchanged and out_err low.
- R4: A codeword with one flipped bit at a payload index comes out with the original payload and out_err low.
- R5: A codeword with one flipped bit at a check index (0, 1, 2, 4, 8 or 16) comes out with the payload unchanged and out_err low, and it counts as a corrected word.
- R6: A codeword with two flipped bits comes out with out_err high. With sub_mode = 0 its out_data is zero.
- R7: With sub_mode = 1, an uncorrectable word whose previous and next words in the same burst are both correctable comes out as floor((prev + next) / 2) of their corrected payloads, computed without overflow. In this mode a word that is not last in its burst is emitted only after the next word of the burst has been accepted.
- R8: With sub_mode = 1, an uncorrectable word that is first in its burst, or last in its burst, or that has an uncorrectable neighbour comes out as zero.
- R9: The read path accepts one word per clock while out_ready is high. Words leave in order with rd_last carried to out_last. While out_valid is high and out_ready is low, the outputs hold and no word is lost.
- R10: cnt_corrected counts single-error words and cnt_uncorrectable counts double-error words. Each adds one per word and stops at 2^CNT_W - 1.
- R11: A high cnt_clr at a clock edge sets both counters to the number of events of that same edge (0 or 1) and clears err_sticky unless an uncorrectable word is counted at that edge.
- R12: err_sticky goes high at the edge where an uncorrectable word is counted. It stays high until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Payload to encode is present |
| wr_ready | output | 1 | Encoder accepts the payload |
| wr_data | input | 26 | Payload to encode |
| enc_valid | output | 1 | Encoded word is present |
| enc_ready | input | 1 | Memory side takes the encoded word |
| enc_word | output | 32 | Encoded codeword |
| rd_valid | input | 1 | Stored codeword is present |
| rd_ready | output | 1 | Decoder accepts the codeword |
| rd_word | input | 32 | Codeword read from memory |
| rd_last | input | 1 | Codeword ends a burst |
| out_valid | output | 1 | Checked payload is present |
| out_ready | input | 1 | Consumer takes the payload |
| out_data | output | 26 | Repaired payload or substitute |
| out_err | output | 1 | Payload was unrecoverable and substituted |
| out_last | output | 1 | Payload ends a burst |
| sub_mode | input | 1 | 0 substitutes zero, 1 substitutes neighbour average |
| cnt_clr | input | 1 | Clears counters and sticky flag |
| cnt_corrected | output | CNT_W | Saturating count of repaired words |
| cnt_uncorrectable | output | CNT_W | Saturating count of unrepairable words |
| err_sticky | output | 1 | Set by any unrepairable word |

## Verification
A counter clear and an uncorrectable word reaching the counter can fall on the same clock edge. The bench provokes this on an idle pipeline. It presents a double-error word and raises cnt_clr exactly two edges after the read handshake, which is the edge at which that word is counted. It then expects the uncorrectable count to read one, the corrected count zero, and the sticky flag set, and a later lone clear to bring all three to zero. The other same-cycle case is in neighbour-average mode under random-looking backpressure: a held word leaves as its successor enters, and the bench checks the released value and the order of the words.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

  localparam int PAR_W  = 5;
  localparam int CODE_W = 1 << PAR_W;
  localparam int DATA_W = CODE_W - PAR_W - 1;
  localparam int SYN_W  = PAR_W;

  typedef enum logic {
    SUB_ZERO   = 1'b0,
    SUB_INTERP = 1'b1
  } sub_mode_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              unc;
    logic              last;
  } dec_word_t;

  // index 0 and powers of two hold check bits
  function automatic logic ecc_is_check_pos(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  function automatic logic [SYN_W-1:0] ecc_syndrome(input logic [CODE_W-1:0] c);
    logic [SYN_W-1:0] s;
    s = '0;
    for (int p = 1; p < CODE_W; p++) begin
      if (c[p]) s = s ^ SYN_W'(p);
    end
    return s;
  endfunction

  function automatic logic [CODE_W-1:0] ecc_encode(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] c;
    logic [SYN_W-1:0]  s;
    int                j;
    c = '0;
    j = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if (!ecc_is_check_pos(p)) begin
        c[p] = d[j];
        j++;
      end
    end
    s = ecc_syndrome(c);
    for (int k = 0; k < SYN_W; k++) begin
      c[1 << k] = s[k];
    end
    c[0] = ^c[CODE_W-1:1];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] ecc_extract(input logic [CODE_W-1:0] c);
    logic [DATA_W-1:0] d;
    int                j;
    d = '0;
    j = 0;
    for (int p = 1; p < CODE_W; p++) begin
      if (!ecc_is_check_pos(p)) begin
        d[j] = c[p];
        j++;
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_word,
  input  logic              out_ready
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_ready && in_valid) begin
      out_word <= ecc_encode(in_data);
    end
  end

endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
  import ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_word,
  input  logic              in_last,
  output logic              out_valid,
  output dec_word_t         out_w,
  output logic              out_cor
);

  // stage 1: syndrome and overall parity
  logic              s1_valid;
  logic [CODE_W-1:0] s1_word;
  logic [SYN_W-1:0]  s1_syn;
  logic              s1_ovp;
  logic              s1_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else if (adv) begin
      s1_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      s1_word <= in_word;
      s1_syn  <= ecc_syndrome(in_word);
      s1_ovp  <= ^in_word;
      s1_last <= in_last;
    end
  end

  // stage 2: classify and repair
  logic [CODE_W-1:0] fixed;
  logic              single_err;
  logic              double_err;

  always_comb begin
    single_err = s1_ovp;
    double_err = !s1_ovp && (s1_syn != '0);
    fixed      = s1_word ^ (CODE_W'(s1_ovp) << s1_syn);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (adv) begin
      out_valid <= s1_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      out_w.data <= ecc_extract(fixed);
      out_w.unc  <= double_err;
      out_w.last <= s1_last;
      out_cor    <= single_err;
    end
  end

endmodule

// File: rtl/ecc_substitute.sv
module ecc_substitute
  import ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  sub_mode_e         mode,
  input  logic              in_valid,
  input  dec_word_t         in_w,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_err,
  output logic              out_last
);

  // one-word hold stage so the next sample is visible
  logic              h_valid;
  dec_word_t         h;
  logic              prev_valid;
  logic              prev_ok;
  logic [DATA_W-1:0] prev_data;

  logic              in_fire;
  logic              emit;
  logic              can_interp;
  logic [DATA_W:0]   pair_sum;
  logic [DATA_W-1:0] sub_val;

  always_comb begin
    in_fire    = in_valid && adv;
    emit       = h_valid && (in_fire || h.last || mode == SUB_ZERO);
    pair_sum   = {1'b0, prev_data} + {1'b0, in_w.data};
    can_interp = (mode == SUB_INTERP) && prev_valid && prev_ok &&
                 in_fire && !in_w.unc && !h.last;
    sub_val    = can_interp ? pair_sum[DATA_W:1] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_valid    <= 1'b0;
      prev_valid <= 1'b0;
      out_valid  <= 1'b0;
    end else if (adv) begin
      out_valid <= emit;
      if (emit) begin
        prev_valid <= !h.last;
      end
      if (in_fire) begin
        h_valid <= 1'b1;
      end else if (emit) begin
        h_valid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      if (emit) begin
        out_data  <= h.unc ? sub_val : h.data;
        out_err   <= h.unc;
        out_last  <= h.last;
        prev_data <= h.data;
        prev_ok   <= !h.unc;
      end
      if (in_fire) begin
        h <= in_w;
      end
    end
  end

endmodule

// File: rtl/ecc_sat_counter.sv
module ecc_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);

  localparam logic [W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= W'(inc);
    end else if (inc && cnt != CNT_MAX) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/ecc_mem_port.sv
module ecc_mem_port
  import ecc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              enc_valid,
  input  logic              enc_ready,
  output logic [CODE_W-1:0] enc_word,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [CODE_W-1:0] rd_word,
  input  logic              rd_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_err,
  output logic              out_last,
  input  logic              sub_mode,
  input  logic              cnt_clr,
  output logic [CNT_W-1:0]  cnt_corrected,
  output logic [CNT_W-1:0]  cnt_uncorrectable,
  output logic              err_sticky
);

  localparam int N_CNT = 2;

  ecc_encoder u_enc (
    .clk      (clk),
    .rst      (rst),
    .in_valid (wr_valid),
    .in_ready (wr_ready),
    .in_data  (wr_data),
    .out_valid(enc_valid),
    .out_word (enc_word),
    .out_ready(enc_ready)
  );

  // whole read pipe moves together when the output can take a word
  logic      adv;
  logic      dec_valid;
  dec_word_t dec_w;
  logic      dec_cor;

  assign adv      = !out_valid || out_ready;
  assign rd_ready = adv;

  ecc_decoder u_dec (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .in_valid (rd_valid),
    .in_word  (rd_word),
    .in_last  (rd_last),
    .out_valid(dec_valid),
    .out_w    (dec_w),
    .out_cor  (dec_cor)
  );

  ecc_substitute u_sub (
    .clk      (clk),
    .rst      (rst),
    .adv      (adv),
    .mode     (sub_mode_e'(sub_mode)),
    .in_valid (dec_valid),
    .in_w     (dec_w),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_err  (out_err),
    .out_last (out_last)
  );

  logic [N_CNT-1:0] ev;
  logic [CNT_W-1:0] cnt [N_CNT];

  assign ev[0] = dec_valid && adv && dec_cor;
  assign ev[1] = dec_valid && adv && dec_w.unc;

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    ecc_sat_counter #(.W(CNT_W)) u_cnt (
      .clk(clk),
      .rst(rst),
      .clr(cnt_clr),
      .inc(ev[g]),
      .cnt(cnt[g])
    );
  end

  assign cnt_corrected     = cnt[0];
  assign cnt_uncorrectable = cnt[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      err_sticky <= 1'b0;
    end else if (ev[1]) begin
      err_sticky <= 1'b1;
    end else if (cnt_clr) begin
      err_sticky <= 1'b0;
    end
  end

endmodule

// File: rtl/ecc_mem_port_chk.sv
module ecc_mem_port_chk
  import ecc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              enc_valid,
  input logic              enc_ready,
  input logic [CODE_W-1:0] enc_word,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_err,
  input logic              out_last,
  input logic              cnt_clr,
  input logic [CNT_W-1:0]  cnt_corrected,
  input logic [CNT_W-1:0]  cnt_uncorrectable,
  input logic              err_sticky
);

  AST_ENC_EVEN_PARITY: assert property (@(posedge clk) disable iff (rst)
    enc_valid |-> (^enc_word) == 1'b0); // R1

  AST_ENC_HOLD: assert property (@(posedge clk) disable iff (rst)
    enc_valid && !enc_ready |=> enc_valid && $stable(enc_word)); // R2

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) &&
                                $stable(out_err) && $stable(out_last)); // R9

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    !cnt_clr |=> cnt_corrected >= $past(cnt_corrected) &&
                 (cnt_corrected - $past(cnt_corrected)) <= CNT_W'(1)); // R10

  AST_CLR_RESULT: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> cnt_corrected <= CNT_W'(1) &&
                cnt_uncorrectable <= CNT_W'(1)); // R11

  AST_STICKY_COVERS_COUNT: assert property (@(posedge clk) disable iff (rst)
    cnt_uncorrectable != '0 |-> err_sticky); // R12

endmodule

bind ecc_mem_port ecc_mem_port_chk #(.CNT_W(CNT_W)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .enc_valid        (enc_valid),
  .enc_ready        (enc_ready),
  .enc_word         (enc_word),
  .out_valid        (out_valid),
  .out_ready        (out_ready),
  .out_data         (out_data),
  .out_err          (out_err),
  .out_last         (out_last),
  .cnt_clr          (cnt_clr),
  .cnt_corrected    (cnt_corrected),
  .cnt_uncorrectable(cnt_uncorrectable),
  .err_sticky       (err_sticky)
);

// File: tb/sim_ecc_mem_port.sv
`timescale 1ns/1ps
module sim_ecc_mem_port;

  localparam int CW = 3;
  localparam logic [CW-1:0] CMAX = '1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [25:0] wr_data = '0;
  logic        enc_valid;
  logic        enc_ready = 1'b1;
  logic [31:0] enc_word;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [31:0] rd_word = '0;
  logic        rd_last = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [25:0] out_data;
  logic        out_err;
  logic        out_last;
  logic        sub_mode = 1'b0;
  logic        cnt_clr = 1'b0;
  logic [CW-1:0] cnt_corrected;
  logic [CW-1:0] cnt_uncorrectable;
  logic        err_sticky;

  always #10 clk = ~clk;

  ecc_mem_port #(.CNT_W(CW)) u0 (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .enc_valid(enc_valid), .enc_ready(enc_ready), .enc_word(enc_word),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_word(rd_word), .rd_last(rd_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_err(out_err), .out_last(out_last),
    .sub_mode(sub_mode), .cnt_clr(cnt_clr),
    .cnt_corrected(cnt_corrected), .cnt_uncorrectable(cnt_uncorrectable),
    .err_sticky(err_sticky)
  );

  int n_checks = 0;
  int n_fail = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // independent encoder: parity k covers indices with bit k set
  function automatic logic [31:0] tb_encode(logic [25:0] d);
    logic [31:0] c;
    int j;
    logic par;
    c = '0;
    j = 0;
    for (int p = 3; p < 32; p++) begin
      if (p != 4 && p != 8 && p != 16) begin
        c[p] = d[j];
        j++;
      end
    end
    for (int k = 0; k < 5; k++) begin
      par = 1'b0;
      for (int p = 1; p < 32; p++) begin
        if (((p >> k) & 1) == 1 && p != (1 << k)) par = par ^ c[p];
      end
      c[1 << k] = par;
    end
    c[0] = ^c[31:1];
    return c;
  endfunction

  // expected output stream
  logic [27:0] exp_q[$];
  string       tag_q[$];
  logic [CW-1:0] exp_cor = '0;
  logic [CW-1:0] exp_unc = '0;

  task automatic push_exp(logic [25:0] d, logic e, logic l, string tag);
    exp_q.push_back({l, e, d});
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk("R9 unexpected output", {4'h0, out_last, out_err, out_data}, 32'hFFFFFFFF);
      end else begin
        logic [27:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {4'h0, out_last, out_err, out_data}, {4'h0, e});
      end
    end
  end

  // burst description
  logic [25:0] bd [0:31];
  int          bk [0:31];
  int          bp1[0:31];
  int          bp2[0:31];

  task automatic send_word(logic [31:0] w, logic last);
    rd_valid = 1'b1;
    rd_word  = w;
    rd_last  = last;
    @(negedge clk);
    while (!rd_ready) @(negedge clk);
    @(posedge clk);
    #1 rd_valid = 1'b0;
  endtask

  task automatic drain(string tag);
    int g;
    g = 0;
    while (exp_q.size() != 0 && g < 2000) begin
      @(posedge clk);
      g++;
    end
    #1;
    chk({tag, " drain"}, 32'(exp_q.size()), 32'd0);
  endtask

  task automatic check_counts(string tag);
    chk({"R10 corrected count ", tag}, 32'(cnt_corrected), 32'(exp_cor));
    chk({"R10 uncorrectable count ", tag}, 32'(cnt_uncorrectable), 32'(exp_unc));
  endtask

  task automatic run_burst(int n, logic mode);
    logic [31:0] w;
    logic [26:0] s;
    logic [25:0] v;
    logic okp, okn;
    string t;
    sub_mode = mode;
    for (int i = 0; i < n; i++) begin
      if (bk[i] == 0) begin
        push_exp(bd[i], 1'b0, i == n - 1, "R3 clean word");
      end else if (bk[i] == 1) begin
        if (bp1[i] == 0 || bp1[i] == 1 || bp1[i] == 2 || bp1[i] == 4 ||
            bp1[i] == 8 || bp1[i] == 16)
          t = "R5 check-bit flip";
        else
          t = "R4 payload flip";
        push_exp(bd[i], 1'b0, i == n - 1, t);
        exp_cor = (exp_cor == CMAX) ? CMAX : exp_cor + 1'b1;
      end else begin
        okp = (i > 0) && (bk[i-1] != 2);
        okn = (i < n - 1) && (bk[i+1] != 2);
        if (!mode) begin
          v = '0; t = "R6 zero substitute";
        end else if (okp && okn) begin
          s = {1'b0, bd[i-1]} + {1'b0, bd[i+1]};
          v = s[26:1]; t = "R7 neighbour average";
        end else begin
          v = '0; t = "R8 interpolation fallback";
        end
        push_exp(v, 1'b1, i == n - 1, t);
        exp_unc = (exp_unc == CMAX) ? CMAX : exp_unc + 1'b1;
      end
    end
    for (int i = 0; i < n; i++) begin
      w = tb_encode(bd[i]);
      if (bk[i] >= 1) w[bp1[i]] = ~w[bp1[i]];
      if (bk[i] == 2) w[bp2[i]] = ~w[bp2[i]];
      send_word(w, i == n - 1);
    end
    drain("R9");
  endtask

  task automatic pulse_clear();
    cnt_clr = 1'b1;
    @(posedge clk);
    #1 cnt_clr = 1'b0;
    exp_cor = '0;
    exp_unc = '0;
  endtask

  task automatic t_reset();
    chk("reset out_valid", 32'(out_valid), 32'd0);
    chk("reset enc_valid R2", 32'(enc_valid), 32'd0);
    chk("reset rd_ready R9", 32'(rd_ready), 32'd1);
    chk("reset sticky R12", 32'(err_sticky), 32'd0);
    check_counts("reset");
  endtask

  task automatic t_encoder();
    logic [25:0] vals [0:4];
    vals[0] = 26'h0000000; vals[1] = 26'h3FFFFFF; vals[2] = 26'h2AAAAAA;
    vals[3] = 26'h1555555; vals[4] = 26'h0000001;
    for (int i = 0; i < 5; i++) begin
      wr_valid = 1'b1;
      wr_data  = vals[i];
      @(posedge clk); #1;
      chk("R1 encoded word", enc_word, tb_encode(vals[i]));
      chk("R2 encoder full rate", 32'(enc_valid), 32'd1);
    end
    wr_valid = 1'b0;
    @(posedge clk); #1;
    chk("R2 encoder empties", 32'(enc_valid), 32'd0);
    enc_ready = 1'b0;
    wr_valid  = 1'b1;
    wr_data   = 26'h0123456;
    @(posedge clk); #1;
    wr_data = 26'h3C0FFEE;
    repeat (3) @(posedge clk);
    #1;
    chk("R2 encoder holds word", enc_word, tb_encode(26'h0123456));
    chk("R2 encoder refuses input", 32'(wr_ready), 32'd0);
    enc_ready = 1'b1;
    @(posedge clk); #1;
    chk("R2 encoder takes next", enc_word, tb_encode(26'h3C0FFEE));
    wr_valid = 1'b0;
    @(posedge clk); #1;
    chk("R2 encoder idle", 32'(enc_valid), 32'd0);
  endtask

  task automatic t_clean();
    for (int i = 0; i < 8; i++) begin
      bd[i] = 26'(32'h01F0_3A5 * (i + 1)) ^ (i[0] ? 26'h3FFFFFF : 26'h0);
      bk[i] = 0;
    end
    run_burst(8, 1'b0);
    check_counts("clean");
  endtask

  task automatic t_single();
    for (int i = 0; i < 32; i++) begin
      bd[i]  = 26'h2B4C3D1 ^ 26'(i * 32'h0011_1111);
      bk[i]  = 1;
      bp1[i] = i;
    end
    run_burst(32, 1'b0);
    check_counts("single flips, saturated");
  endtask

  task automatic t_double_zero();
    pulse_clear();
    for (int i = 0; i < 6; i++) begin
      bd[i] = 26'h3000000 + 26'(i * 7);
      bk[i] = 0;
    end
    bk[0] = 2; bp1[0] = 0;  bp2[0] = 31;
    bk[2] = 2; bp1[2] = 5;  bp2[2] = 6;
    bk[3] = 2; bp1[3] = 16; bp2[3] = 17;
    bk[5] = 1; bp1[5] = 20;
    run_burst(6, 1'b0);
    check_counts("double zero mode");
  endtask

  task automatic t_interp();
    for (int i = 0; i < 10; i++) begin
      bd[i] = 26'h3FFFF00 - 26'(i * 32'h0031_0101);
      bk[i] = 0;
    end
    bk[0] = 2; bp1[0] = 3;  bp2[0] = 9;
    bk[2] = 2; bp1[2] = 1;  bp2[2] = 30;
    bk[3] = 1; bp1[3] = 11;
    bk[4] = 2; bp1[4] = 7;  bp2[4] = 8;
    bk[6] = 2; bp1[6] = 12; bp2[6] = 13;
    bk[7] = 2; bp1[7] = 0;  bp2[7] = 2;
    bk[9] = 2; bp1[9] = 25; bp2[9] = 26;
    run_burst(10, 1'b1);
    check_counts("interpolation");
  endtask

  task automatic t_interp_hold();
    sub_mode = 1'b1;
    push_exp(26'h0ABCDEF, 1'b0, 1'b0, "R7 held word released");
    push_exp(26'h1234567, 1'b0, 1'b1, "R7 burst end");
    send_word(tb_encode(26'h0ABCDEF), 1'b0);
    repeat (8) @(posedge clk);
    #1;
    chk("R7 word held until next arrives", 32'(out_valid), 32'd0);
    send_word(tb_encode(26'h1234567), 1'b1);
    drain("R7");
  endtask

  task automatic t_backpressure();
    for (int i = 0; i < 12; i++) begin
      bd[i] = 26'h155AA33 + 26'(i * 32'h0002_0405);
      bk[i] = (i % 4 == 1) ? 2 : ((i % 3 == 0) ? 1 : 0);
      bp1[i] = (i * 5) % 32;
      bp2[i] = (i * 5 + 3) % 32;
    end
    fork
      run_burst(12, 1'b1);
      begin
        for (int i = 0; i < 60; i++) begin
          @(posedge clk);
          #1 out_ready = (i % 3) != 0 && (i % 7) != 2;
        end
        out_ready = 1'b1;
      end
    join
    out_ready = 1'b1;
    check_counts("backpressure");
  endtask

  task automatic t_clear_same_cycle();
    logic [31:0] w;
    sub_mode = 1'b0;
    w = tb_encode(26'h0000155);
    w[3] = ~w[3];
    w[9] = ~w[9];
    push_exp(26'h0, 1'b1, 1'b1, "R6 word counted on clear edge");
    rd_valid = 1'b1;
    rd_word  = w;
    rd_last  = 1'b1;
    @(posedge clk);
    #1 rd_valid = 1'b0;
    @(posedge clk);
    #1 cnt_clr = 1'b1;
    @(posedge clk);
    #1 cnt_clr = 1'b0;
    chk("R11 event on clear edge counted", 32'(cnt_uncorrectable), 32'd1);
    chk("R11 other counter cleared", 32'(cnt_corrected), 32'd0);
    chk("R12 sticky set despite clear", 32'(err_sticky), 32'd1);
    drain("R11");
    exp_cor = '0;
    exp_unc = 3'd1;
    for (int i = 0; i < 4; i++) begin
      bd[i] = 26'h0F0F0F0 + 26'(i);
      bk[i] = 0;
    end
    run_burst(4, 1'b0);
    chk("R12 sticky holds over clean words", 32'(err_sticky), 32'd1);
    pulse_clear();
    chk("R11 lone clear sticky", 32'(err_sticky), 32'd0);
    check_counts("after lone clear R11");
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_encoder();
    t_clean();
    t_single();
    t_double_zero();
    t_interp();
    t_interp_hold();
    t_backpressure();
    t_clear_same_cycle();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog R9: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule